// File: doc/BRIEF.md
# Sequential 32-bit Integer Multiply Unit

This block runs the four integer multiply operations of a 32-bit scalar core: the low-half product and the three high-half products. The three high-half forms differ only in how the operands are read. Both can be signed, both can be unsigned, or the first can be signed and the second unsigned. The unit reduces each operand to a magnitude and a sign flag. It multiplies the magnitudes with a shift-and-add loop that retires `DIGIT` multiplier bits per clock. When the loop ends, it negates the 64-bit product if the signs differ and returns the requested half.

The core issue logic offers one operation at a time over a valid/ready handshake. The unit takes the operation when `in_ready` is high and `in_valid` is sampled high at a clock edge. It then stays busy for a fixed number of cycles. It holds the result with `out_valid` until the consumer raises `out_ready`. The controller has three states. `IDLE` accepts work; the transition `IDLE->CALC` is *accept*. `CALC` runs `XLEN/DIGIT` step cycles; it stays in `CALC` on *step* and leaves on *last step* (`CALC->FIN`). `FIN` presents the result; it stays in `FIN` on *stall* while `out_ready` is low and leaves on *deliver* (`FIN->IDLE`).

Operation select `in_op` is encoded 00 = low product, 01 = high signed×signed, 10 = high signed×unsigned, 11 = high unsigned×unsigned.

Top module: `imul32_unit`

## Requirements
- R1: With `in_op` = 00, `out_result` equals bits 31:0 of the product of `in_a` and `in_b`.
- R2: With `in_op` = 01, both operands are two's-complement signed and `out_result` equals bits 63:32 of their 64-bit product.
- R3: With `in_op` = 11, both operands are unsigned and `out_result` equals bits 63:32 of their product.
- R4: With `in_op` = 10, `in_a` is signed and `in_b` is unsigned, and `out_result` equals bits 63:32 of the product; 0x80000000 by 0xFFFFFFFF gives 0x80000000.
- R5: The op-00 result does not depend on operand signedness: it equals the low 32 bits of the unsigned product and also of the signed product of the same bit patterns.
- R6: `in_ready` is high only in `IDLE`. An operation is accepted only at an edge where `in_valid` and `in_ready` are both high. Input changes and `in_valid` pulses while busy have no effect on the result that is pending.
- R7: `out_valid` rises exactly `XLEN/DIGIT` clock edges after the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` holds its value. Each accepted operation yields exactly one delivery, and `out_valid` falls after the delivering edge.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.
- R10: When the signed product fits in 32 bits, the op-01 result equals the sign extension of bit 31 of the op-00 result for the same operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to take an operation |
| in_op | input | 2 | Operation select (00 low, 01 high s×s, 10 high s×u, 11 high u×u) |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Selected 32-bit half of the product |

## Verification
The bench builds the unit with `XLEN` = 32 and `DIGIT` = 8, which gives a four-cycle step loop. With so short a loop, many back-to-back operations, stalled deliveries and input pokes while busy fit in a short run. Because `DIGIT` is wide, every partial-product term is exercised on each step. The operand set includes the most negative value, all ones, zero and small signed values. These reach the negation path, the one mixed-signedness case that produces the most negative high half, and the region where the high half is only sign extension.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        OP_LO    = 2'b00,
        OP_HI_SS = 2'b01,
        OP_HI_SU = 2'b10,
        OP_HI_UU = 2'b11
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_FIN
    } mul_state_e;

    // First operand is read as signed for the signed and mixed high forms.
    function automatic logic first_is_signed(input mul_op_e op);
        return (op == OP_HI_SS) || (op == OP_HI_SU);
    endfunction

    // Second operand is read as signed only for the fully signed high form.
    function automatic logic second_is_signed(input mul_op_e op);
        return (op == OP_HI_SS);
    endfunction

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic         treat_signed,
    output logic [W-1:0] magnitude,
    output logic         negative
);

    always_comb begin
        negative = treat_signed && value[W-1];
        // The most negative value negates onto itself, which is the right
        // unsigned magnitude 2^(W-1).
        if (negative) begin
            magnitude = (~value) + W'(1);
        end else begin
            magnitude = value;
        end
    end

endmodule

// File: rtl/imul_step_core.sv
module imul_step_core #(
    parameter int W = 32,
    parameter int D = 4
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);

    localparam int PW = W + D;

    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] prod_q;
    logic [D-1:0]   digit;
    logic [PW-1:0]  terms [D];
    logic [PW-1:0]  pp;
    logic [PW-1:0]  upper_sum;
    logic [2*W-1:0] prod_next;

    assign digit = prod_q[D-1:0];

    genvar gi;
    generate
        for (gi = 0; gi < D; gi++) begin : g_term
            assign terms[gi] = digit[gi] ? (PW'(mcand_q) << gi) : '0;
        end
    endgenerate

    always_comb begin
        pp = '0;
        for (int i = 0; i < D; i++) begin
            pp = pp + terms[i];
        end
    end

    // The upper half plus one digit's partial product fits in W+D bits.
    assign upper_sum = PW'(prod_q[2*W-1:W]) + pp;
    assign prod_next = {upper_sum, prod_q[W-1:D]};

    always_ff @(posedge clk) begin
        if (load) begin
            mcand_q <= mcand;
            prod_q  <= {{W{1'b0}}, mplier};
        end else if (step) begin
            prod_q  <= prod_next;
        end
    end

    assign product = prod_q;

endmodule

// File: rtl/imul_result_sel.sv
module imul_result_sel
    import imul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] magnitude_product,
    input  logic           negate,
    input  mul_op_e        op,
    output logic [W-1:0]   result
);

    logic [2*W-1:0] signed_product;

    always_comb begin
        if (negate) begin
            signed_product = (~magnitude_product) + (2*W)'(1);
        end else begin
            signed_product = magnitude_product;
        end
        unique case (op)
            OP_LO:                       result = signed_product[W-1:0];
            OP_HI_SS, OP_HI_SU, OP_HI_UU: result = signed_product[2*W-1:W];
            default:                     result = signed_product[W-1:0];
        endcase
    end

endmodule

// File: rtl/imul32_unit.sv
module imul32_unit
    import imul_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DIGIT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_result
);

    localparam int STEPS = XLEN / DIGIT;
    localparam int CW    = $clog2(STEPS + 1);

    mul_state_e      state_q, state_d;
    mul_op_e         op_q;
    logic            neg_q;
    logic [CW-1:0]   cnt_q;

    logic            accept;
    logic            last_step;
    logic            do_step;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            neg_a, neg_b;
    logic [2*XLEN-1:0] prod;

    assign accept    = (state_q == ST_IDLE) && in_valid;
    assign last_step = (cnt_q == CW'(STEPS - 1));
    assign do_step   = (state_q == ST_CALC);

    imul_operand_prep #(.W(XLEN)) u_prep_a (
        .value        (in_a),
        .treat_signed (first_is_signed(mul_op_e'(in_op))),
        .magnitude    (mag_a),
        .negative     (neg_a)
    );

    imul_operand_prep #(.W(XLEN)) u_prep_b (
        .value        (in_b),
        .treat_signed (second_is_signed(mul_op_e'(in_op))),
        .magnitude    (mag_b),
        .negative     (neg_b)
    );

    imul_step_core #(.W(XLEN), .D(DIGIT)) u_core (
        .clk     (clk),
        .load    (accept),
        .step    (do_step),
        .mcand   (mag_a),
        .mplier  (mag_b),
        .product (prod)
    );

    imul_result_sel #(.W(XLEN)) u_sel (
        .magnitude_product (prod),
        .negate            (neg_q),
        .op                (op_q),
        .result            (out_result)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, step, last step, stall, deliver
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_CALC;
            ST_CALC: if (last_step) state_d = ST_FIN;
            ST_FIN:  if (out_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Captured operation attributes and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_LO;
            neg_q <= 1'b0;
            cnt_q <= '0;
        end else if (accept) begin
            op_q  <= mul_op_e'(in_op);
            neg_q <= neg_a ^ neg_b;
            cnt_q <= '0;
        end else if (do_step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_CALC: ;
            ST_FIN:  out_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/imul32_unit_chk.sv
module imul32_unit_chk #(
    parameter int XLEN  = 32,
    parameter int DIGIT = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_result
);

    localparam int STEPS = XLEN / DIGIT;
    localparam int LW    = $clog2(STEPS + 1) + 1;

    logic          trk;
    logic [LW-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk <= 1'b0;
            lat <= '0;
        end else if (in_valid && in_ready) begin
            trk <= 1'b1;
            lat <= '0;
        end else begin
            if (trk && !out_valid) lat <= lat + LW'(1);
            if (out_valid)         trk <= 1'b0;
        end
    end

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    ready_excludes_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R7
    fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (trk && lat == LW'(STEPS)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

    // R8
    single_delivery_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

endmodule

bind imul32_unit imul32_unit_chk #(.XLEN(XLEN), .DIGIT(DIGIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
);

// File: tb/imul32_unit_test.sv
module imul32_unit_test;

    localparam int XLEN  = 32;
    localparam int DIGIT = 8;
    localparam int STEPS = XLEN / DIGIT;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [1:0]      in_op = 2'b00;
    logic [XLEN-1:0] in_a = '0;
    logic [XLEN-1:0] in_b = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [XLEN-1:0] out_result;

    int checks   = 0;
    int failures = 0;
    int issued   = 0;
    int delivered = 0;

    // model state
    bit              m_busy = 0;
    bit              m_outv = 0;
    int              m_cnt  = 0;
    logic [1:0]      m_op   = 0;
    logic [XLEN-1:0] m_res  = 0;

    always #5 clk = ~clk;

    imul32_unit #(.XLEN(XLEN), .DIGIT(DIGIT)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result)
    );

    function automatic logic [31:0] ref_mul(input logic [1:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        logic signed [65:0] ea, eb, p;
        ea = (op == 2'b01 || op == 2'b10) ? {{34{a[31]}}, a} : {34'b0, a};
        eb = (op == 2'b01) ? {{34{b[31]}}, b} : {34'b0, b};
        p  = ea * eb;
        return (op == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle reference model, evaluated 1 ns after each edge.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            m_busy = 0;
            m_outv = 0;
        end else if (m_outv && out_ready) begin
            m_outv = 0;
            m_busy = 0;
            delivered++;
        end else if (!m_busy && in_valid) begin
            m_busy = 1;
            m_cnt  = STEPS;
            m_op   = in_op;
            m_res  = ref_mul(in_op, in_a, in_b);
        end else if (m_busy && !m_outv) begin
            m_cnt--;
            if (m_cnt == 0) m_outv = 1;
        end
        if (!rst) begin
            check("R6 in_ready", 64'(in_ready), 64'(!m_busy));
            check("R7 out_valid timing", 64'(out_valid), 64'(m_outv));
            if (m_outv) check(op_tag(m_op), 64'(out_result), 64'(m_res));
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input int hold,
                          input bit poke, output logic [31:0] res);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
        if (hold > 0) out_ready = 1'b0;
        issued++;
        @(negedge clk);
        if (poke) begin
            // R6: offer different work while busy; it must be ignored
            in_op = ~op; in_a = ~a; in_b = b ^ 32'h5a5a_0f0f;
        end else begin
            in_valid = 1'b0;
        end
        while (!out_valid) @(negedge clk);
        in_valid = 1'b0;
        repeat (hold) @(negedge clk);
        res = out_result;
        out_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] r, lo, hi;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 in_ready", 64'(in_ready), 64'(1));
        check("R9 out_valid", 64'(out_valid), 64'(0));
        rst = 1'b0;

        // R4 corner: most negative times all ones
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, r);
        check("R4 corner", 64'(r), 64'h8000_0000);
        // R2 signed high, most negative squared
        run_op(2'b01, 32'h8000_0000, 32'h8000_0000, 0, 0, r);
        check("R2 min*min", 64'(r), 64'h4000_0000);
        // R3 unsigned high, all ones squared
        run_op(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, r);
        check("R3 max*max", 64'(r), 64'hFFFF_FFFE);
        // R1 low product
        run_op(2'b00, 32'h0001_0003, 32'h0002_0005, 0, 0, r);
        check("R1 low", 64'(r), 64'h000b_000f);

        // R5 low result independent of signedness
        run_op(2'b00, 32'hFFFF_FFF9, 32'h8000_0003, 0, 0, lo);
        check("R5 vs unsigned", 64'(lo),
              64'(ref_mul(2'b00, 32'hFFFF_FFF9, 32'h8000_0003)));
        begin
            logic signed [63:0] sp;
            sp = $signed(64'(signed'(32'hFFFF_FFF9))) *
                 $signed(64'(signed'(32'h8000_0003)));
            check("R5 vs signed", 64'(lo), 64'(sp[31:0]));
        end

        // R10 small signed products: high half is sign extension of low
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a, b;
            a = (k[0]) ? 32'hFFFF_F000 + 32'(k) : 32'h0000_1234 + 32'(k);
            b = (k[1]) ? 32'hFFFF_FF85 : 32'h0000_0321;
            run_op(2'b00, a, b, 0, 0, lo);
            run_op(2'b01, a, b, 0, 0, hi);
            check("R10 sign extension", 64'(hi), 64'({32{lo[31]}}));
        end

        // R8 stalled delivery holds result
        run_op(2'b01, 32'hDEAD_BEEF, 32'h1234_5678, 6, 0, r);
        check("R8 held result", 64'(r),
              64'(ref_mul(2'b01, 32'hDEAD_BEEF, 32'h1234_5678)));

        // R6 pokes while busy are ignored
        run_op(2'b10, 32'h7FFF_FFFF, 32'h8000_0001, 2, 1, r);
        check("R6 ignored while busy", 64'(r),
              64'(ref_mul(2'b10, 32'h7FFF_FFFF, 32'h8000_0001)));

        // Random mix, all ops, occasional stall and poke
        for (int n = 0; n < 80; n++) begin
            logic [1:0] op;
            logic [31:0] a, b;
            op = 2'($urandom_range(0, 3));
            a = $urandom;
            b = $urandom;
            if (n % 9 == 0) a = 32'h8000_0000;
            if (n % 7 == 0) b = 32'hFFFF_FFFF;
            if (n % 11 == 0) a = 32'h0;
            run_op(op, a, b, (n % 5 == 0) ? 3 : 0, (n % 6 == 0), r);
            check(op_tag(op), 64'(r), 64'(ref_mul(op, a, b)));
        end

        repeat (STEPS + 3) @(negedge clk);
        // R8 one delivery per accepted operation
        check("R8 delivery count", 64'(delivered), 64'(issued));
        check("R8 idle after drain", 64'(out_valid), 64'(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule